// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Front End

This block is the device-side receive and transmit engine of a serial NOR flash. A host selects the device with an active-low chip select and clocks it with a serial clock. The host sends an 8-bit opcode, and for memory commands a 24-bit address. The block turns that serial stream into decoded opcode, address and write-data strobes for the memory core. For read commands it asks the core for read bytes and shifts them back out. The lane width is one, two or four bits per serial clock, and a protocol-mode input selects it at run time.

The serial clock, chip select and hold inputs are oversampled by the system clock `clk`, so the whole block lives in one clock domain. Inputs are captured on detected rising serial edges. Read data moves on detected falling serial edges. The core sees only single-cycle strobes and a one-cycle read-request handshake.

A fast read waits a configurable number of dummy clocks before data starts. A hold input pauses the transfer, except in quad mode, where that pin is a data lane. After reset the block stays deaf until chip select has gone through a falling edge.

Top module: `sflash_lane_frontend`

## Requirements
- R1: Opcode, address and write data are captured on rising serial-clock edges, most significant bit first; a full opcode is 8 bits and a full address is 24 bits (first address byte lands in bits 23:16).
- R2: While `cs_n` is high, `dq_oe` is all zero in the same cycle.
- R3: After reset no opcode is accepted until `cs_n` has shown a falling edge; a transfer with `cs_n` held low since reset produces no strobe.
- R4: Outside quad mode, `hold_n` low while selected forces `dq_oe` to zero and ignores serial edges and input lanes; the transfer resumes where it stopped once `hold_n` returns high.
- R5: In quad mode (`lane_mode` = 2'b10) `hold_n` has no effect while selected.
- R6: `lane_mode` 2'b00 moves one bit per clock (in on `dq_i[0]`, out on `dq_o[1]`, `dq_oe` = 4'b0010), 2'b01 two bits (`dq[1]` is the higher bit, `dq_oe` = 4'b0011), 2'b10 four bits (`dq[3]` highest, `dq_oe` = 4'b1111); 2'b11 behaves as 2'b00.
- R7: Opcode 8'h03 takes an address, then reads; 8'h0B takes an address and dummy clocks, then reads; 8'h02 takes an address, then write bytes; 8'h05 and 8'h9F read at once with no address; any other opcode is followed directly by write bytes.
- R8: After the address of opcode 8'h0B, exactly `dummy_clks` rising serial edges pass with outputs undriven before the first data falling edge; zero means none.
- R9: `cmd_stb`, `addr_stb` and `wdat_stb` are single-cycle pulses, never two at once, and `cmd_code`, `addr_val` and `wdat` hold their value until the next strobe of their kind.
- R10: `rreq` pulses for one cycle when a read phase starts and again at the start of each outgoing byte, and `rdat` is taken during the `rreq` cycle, so after N bytes out N+1 requests have been made.
- R11: Raising `cs_n` mid-command aborts it; the next selection starts with a fresh opcode.
- R12: Output lanes change only after falling serial edges and stay constant while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| hold_n | input | 1 | Active-low transfer pause |
| dq_i | input | 4 | Input value of the four data lanes |
| dq_o | output | 4 | Output value of the four data lanes |
| dq_oe | output | 4 | Per-lane output enable |
| lane_mode | input | 2 | Protocol lane width: 00 single, 01 dual, 10 quad |
| dummy_clks | input | 4 | Dummy clock count for fast read |
| cmd_stb | output | 1 | Opcode received pulse |
| cmd_code | output | 8 | Last received opcode |
| addr_stb | output | 1 | Address complete pulse |
| addr_val | output | 24 | Last received address |
| wdat_stb | output | 1 | Write byte received pulse |
| wdat | output | 8 | Last received write byte |
| rreq | output | 1 | Read byte request to the core |
| rdat | input | 8 | Read byte from the core, valid while `rreq` is high |

## Verification
Each strobe rises one system clock after the clock edge that detects the rising serial edge completing its byte. The output lanes update one system clock after the edge that detects a falling serial edge. `rreq` appears one cycle after a read phase starts or a byte boundary is crossed, and `rdat` is sampled in that same cycle. The bench holds each serial half period for several system clocks. It samples the lanes three clocks after a falling edge and again late in the high phase, and it reads strobe values two clocks after the final rising edge, so every check lands after its result has settled.

// File: rtl/sfl_fe_pkg.sv
`timescale 1ns/1ps
package sfl_fe_pkg;

  localparam logic [1:0] LM_X1 = 2'b00;
  localparam logic [1:0] LM_X2 = 2'b01;
  localparam logic [1:0] LM_X4 = 2'b10;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FAST  = 8'h0B;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_STAT  = 8'h05;
  localparam logic [7:0] OPC_IDENT = 8'h9F;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_DUMMY, PH_READ, PH_WRITE
  } phase_e;

  typedef enum logic [2:0] {
    CK_ADDR_READ, CK_ADDR_FAST, CK_ADDR_PROG, CK_REG_READ, CK_REG_WRITE
  } cmd_kind_e;

  function automatic logic [2:0] lanes_per_clk(input logic [1:0] m);
    case (m)
      LM_X2:   return 3'd2;
      LM_X4:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] merge_lanes(input logic [7:0] sh, input logic [3:0] dq,
                                             input logic [1:0] m);
    case (m)
      LM_X2:   return {sh[5:0], dq[1:0]};
      LM_X4:   return {sh[3:0], dq};
      default: return {sh[6:0], dq[0]};
    endcase
  endfunction

  function automatic logic [3:0] split_lanes(input logic [7:0] src, input logic [1:0] m);
    case (m)
      LM_X2:   return {2'b00, src[7:6]};
      LM_X4:   return src[7:4];
      default: return {2'b00, src[7], 1'b0};
    endcase
  endfunction

  function automatic logic [3:0] drive_mask(input logic [1:0] m);
    case (m)
      LM_X2:   return 4'b0011;
      LM_X4:   return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      OPC_READ:            return CK_ADDR_READ;
      OPC_FAST:            return CK_ADDR_FAST;
      OPC_PROG:            return CK_ADDR_PROG;
      OPC_STAT, OPC_IDENT: return CK_REG_READ;
      default:             return CK_REG_WRITE;
    endcase
  endfunction

endpackage

// File: rtl/sfl_fe_edges.sv
`timescale 1ns/1ps
module sfl_fe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall
);
  logic sck_q, cs_q;

  // cs_q resets low so a select already held at reset release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
  assign cs_fall  = ~cs_n & cs_q;
endmodule

// File: rtl/sfl_fe_rx.sv
`timescale 1ns/1ps
module sfl_fe_rx
  import sfl_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift,
  input  logic [1:0] mode,
  input  logic [3:0] dq_i,
  output logic       done,
  output logic [7:0] byte_o
);
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic [3:0] sum;

  assign sum    = cnt_q + {1'b0, lanes_per_clk(mode)};
  assign byte_o = merge_lanes(sh_q, dq_i, mode);
  assign done   = shift & (sum == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      sh_q  <= byte_o;
      cnt_q <= done ? 4'd0 : sum;
    end
  end

  assert_rx_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (cnt_q < 4'd8));
endmodule

// File: rtl/sfl_fe_tx.sv
`timescale 1ns/1ps
module sfl_fe_tx
  import sfl_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  logic       shift,
  input  logic [1:0] mode,
  input  logic [7:0] rdat,
  output logic       rreq,
  output logic       drive,
  output logic [3:0] lanes_o
);
  logic [7:0] pend_q, osh_q, src;
  logic [3:0] ocnt_q, osum;
  logic [2:0] bpc;
  logic       byte_edge;

  assign bpc       = lanes_per_clk(mode);
  assign byte_edge = (ocnt_q == 4'd0);
  assign src       = byte_edge ? pend_q : osh_q;
  assign osum      = ocnt_q + {1'b0, bpc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      osh_q   <= '0;
      ocnt_q  <= '0;
      rreq    <= 1'b0;
      drive   <= 1'b0;
      lanes_o <= '0;
    end else if (clr) begin
      ocnt_q  <= '0;
      rreq    <= 1'b0;
      drive   <= 1'b0;
      lanes_o <= '0;
    end else begin
      rreq <= start | (shift & byte_edge);
      if (rreq) pend_q <= rdat;
      if (shift) begin
        lanes_o <= split_lanes(src, mode);
        osh_q   <= src << bpc;
        ocnt_q  <= (osum == 4'd8) ? 4'd0 : osum;
        drive   <= 1'b1;
      end
    end
  end

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rreq |=> !rreq);
  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !drive);
endmodule

// File: rtl/sflash_lane_frontend.sv
`timescale 1ns/1ps
module sflash_lane_frontend
  import sfl_fe_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int DUMMY_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    hold_n,
  input  logic [3:0]              dq_i,
  output logic [3:0]              dq_o,
  output logic [3:0]              dq_oe,
  input  logic [1:0]              lane_mode,
  input  logic [DUMMY_W-1:0]      dummy_clks,
  output logic                    cmd_stb,
  output logic [7:0]              cmd_code,
  output logic                    addr_stb,
  output logic [ADDR_BYTES*8-1:0] addr_val,
  output logic                    wdat_stb,
  output logic [7:0]              wdat,
  output logic                    rreq,
  input  logic [7:0]              rdat
);
  localparam int AW   = ADDR_BYTES * 8;
  localparam int AB_W = $clog2(ADDR_BYTES + 1);

  // named internal events
  logic sck_rise, sck_fall, cs_fall;
  logic armed_q, active, hold_act, srise, sfall;
  logic rx_shift, rx_done, tx_shift, tx_start, tx_drive;
  logic [7:0] rx_byte;
  logic [3:0] tx_lanes;
  logic last_addr, dummy_end;
  logic [AW-1:0] addr_next, addr_sh_q;
  logic [AB_W-1:0] abyte_q;
  logic [DUMMY_W-1:0] dcnt_q;
  phase_e phase_q;
  cmd_kind_e kind_q, op_kind;

  sfl_fe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall));

  assign hold_act = ~cs_n & ~hold_n & (lane_mode != LM_X4);
  assign active   = armed_q & ~cs_n;
  assign srise    = sck_rise & active & ~hold_act;
  assign sfall    = sck_fall & active & ~hold_act;

  assign rx_shift = srise & ((phase_q == PH_OPCODE) | (phase_q == PH_ADDR) |
                             (phase_q == PH_WRITE));
  assign tx_shift = sfall & (phase_q == PH_READ);

  sfl_fe_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(~active), .shift(rx_shift),
    .mode(lane_mode), .dq_i(dq_i), .done(rx_done), .byte_o(rx_byte));

  assign op_kind   = classify(rx_byte);
  assign last_addr = (abyte_q == AB_W'(ADDR_BYTES - 1));
  assign addr_next = {addr_sh_q[AW-9:0], rx_byte};
  assign dummy_end = ({1'b0, dcnt_q} + 1'b1) == {1'b0, dummy_clks};

  always_comb begin
    tx_start = 1'b0;
    if (rx_done && phase_q == PH_OPCODE && op_kind == CK_REG_READ) tx_start = 1'b1;
    if (rx_done && phase_q == PH_ADDR && last_addr &&
        (kind_q == CK_ADDR_READ || (kind_q == CK_ADDR_FAST && dummy_clks == '0)))
      tx_start = 1'b1;
    if (srise && phase_q == PH_DUMMY && dummy_end) tx_start = 1'b1;
  end

  sfl_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(~active), .start(tx_start), .shift(tx_shift),
    .mode(lane_mode), .rdat(rdat), .rreq(rreq), .drive(tx_drive), .lanes_o(tx_lanes));

  assign dq_o  = tx_lanes;
  assign dq_oe = (tx_drive & active & ~hold_act) ? drive_mask(lane_mode) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      phase_q   <= PH_OPCODE;
      kind_q    <= CK_REG_WRITE;
      abyte_q   <= '0;
      dcnt_q    <= '0;
      addr_sh_q <= '0;
      cmd_code  <= '0;
      addr_val  <= '0;
      wdat      <= '0;
      cmd_stb   <= 1'b0;
      addr_stb  <= 1'b0;
      wdat_stb  <= 1'b0;
    end else begin
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      wdat_stb <= 1'b0;
      if (cs_fall) armed_q <= 1'b1;
      if (!active) begin
        phase_q <= PH_OPCODE;
        abyte_q <= '0;
        dcnt_q  <= '0;
      end else begin
        case (phase_q)
          PH_OPCODE: if (rx_done) begin
            cmd_code <= rx_byte;
            cmd_stb  <= 1'b1;
            kind_q   <= op_kind;
            case (op_kind)
              CK_REG_READ:  phase_q <= PH_READ;
              CK_REG_WRITE: phase_q <= PH_WRITE;
              default:      phase_q <= PH_ADDR;
            endcase
          end
          PH_ADDR: if (rx_done) begin
            addr_sh_q <= addr_next;
            abyte_q   <= abyte_q + 1'b1;
            if (last_addr) begin
              addr_val <= addr_next;
              addr_stb <= 1'b1;
              abyte_q  <= '0;
              case (kind_q)
                CK_ADDR_READ: phase_q <= PH_READ;
                CK_ADDR_FAST: phase_q <= (dummy_clks == '0) ? PH_READ : PH_DUMMY;
                default:      phase_q <= PH_WRITE;
              endcase
            end
          end
          PH_DUMMY: if (srise) begin
            dcnt_q <= dcnt_q + 1'b1;
            if (dummy_end) begin
              dcnt_q  <= '0;
              phase_q <= PH_READ;
            end
          end
          PH_WRITE: if (rx_done) begin
            wdat     <= rx_byte;
            wdat_stb <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_no_cmd_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !cmd_stb);
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase_q == PH_OPCODE));
  assert_hold_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |=> $stable(phase_q));
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, addr_stb, wdat_stb}));
endmodule

// File: tb/sflash_lane_frontend_tb.sv
`timescale 1ns/1ps
module sflash_lane_frontend_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, hold_n = 1'b1;
  logic [3:0] dq_i = '0, dq_o, dq_oe;
  logic [1:0] lane_mode = 2'b00;
  logic [3:0] dummy_clks = '0;
  logic cmd_stb, addr_stb, wdat_stb, rreq;
  logic [7:0] cmd_code, wdat, rdat;
  logic [23:0] addr_val;

  int checks = 0, fails = 0, glitches = 0;
  int n_cmd = 0, n_addr = 0, n_wr = 0;
  logic [7:0] rq_cnt;
  logic [3:0] oe_smp;

  always #4 clk = ~clk;

  sflash_lane_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .lane_mode(lane_mode),
    .dummy_clks(dummy_clks), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .addr_stb(addr_stb), .addr_val(addr_val), .wdat_stb(wdat_stb), .wdat(wdat),
    .rreq(rreq), .rdat(rdat));

  function automatic logic [7:0] core_fn(input logic [7:0] n);
    return (n * 8'd37) ^ 8'h5A;
  endfunction

  // memory core model: byte n is served on the n-th request
  always @(posedge clk) begin
    if (!rst_n) rq_cnt <= '0;
    else if (rreq) rq_cnt <= rq_cnt + 8'd1;
  end
  assign rdat = core_fn(rq_cnt);

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_stb)  n_cmd  <= n_cmd + 1;
      if (addr_stb) n_addr <= n_addr + 1;
      if (wdat_stb) n_wr   <= n_wr + 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int bw(input logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  // one serial clock: drive lanes, sample before the rise, watch the high phase
  task automatic sclk(input logic [3:0] din, output logic [3:0] dout);
    dq_i = din;
    repeat (3) @(negedge clk);
    dout = dq_o & dq_oe;
    oe_smp = dq_oe;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    if ((dq_o & dq_oe) !== dout) glitches++;
    @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [3:0] d;
    int w;
    w = bw(lane_mode);
    for (int k = 8 - w; k >= 0; k -= w) sclk(4'((b >> k) & ((1 << w) - 1)), d);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic [3:0] d;
    int w;
    w = bw(lane_mode);
    b = '0;
    for (int k = 0; k < 8; k += w) begin
      sclk(4'b0000, d);
      case (lane_mode)
        2'b01:   b = {b[5:0], d[1:0]};
        2'b10:   b = {b[3:0], d};
        default: b = {b[6:0], d[1]};
      endcase
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; repeat (3) @(negedge clk);
  endtask
  task automatic desel();
    @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] mode; logic [7:0] op; logic [23:0] addr; logic [7:0] wd; logic [3:0] dmy;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'b00, 8'h02, 24'h123456, 8'hA7, 4'd0},
    '{2'b01, 8'h02, 24'hABCDEF, 8'h3C, 4'd0},
    '{2'b10, 8'h02, 24'h00FF01, 8'hE1, 4'd0},
    '{2'b00, 8'h03, 24'h0A0B0C, 8'h00, 4'd0},
    '{2'b01, 8'h0B, 24'h102030, 8'h00, 4'd2},
    '{2'b10, 8'h0B, 24'h7F8081, 8'h00, 4'd5}
  };

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b, base;
    logic [3:0] d;
    int c0, a0, w0, oe_acc;
    repeat (3) @(negedge clk);
    chk("R2 oe in reset", 32'(dq_oe), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset cmd_code", 32'(cmd_code), 32'h0);
    chk("R9 reset addr_val", 32'(addr_val), 32'h0);

    // R3: select held low since reset must not arm the front end
    send_byte(8'h02);
    repeat (2) @(negedge clk);
    chk("R3 no opcode before cs fall", 32'(n_cmd), 32'h0);
    desel();

    // table of commands across lane widths
    foreach (VECS[i]) begin
      lane_mode = VECS[i].mode;
      dummy_clks = VECS[i].dmy;
      c0 = n_cmd; a0 = n_addr; w0 = n_wr; base = rq_cnt;
      sel();
      send_byte(VECS[i].op);
      for (int k = 2; k >= 0; k--) send_byte(VECS[i].addr[k*8 +: 8]);
      repeat (2) @(negedge clk);
      chk("R1 R6 opcode", 32'(cmd_code), 32'(VECS[i].op));
      chk("R1 R6 address", 32'(addr_val), 32'(VECS[i].addr));
      chk("R9 one cmd and one addr strobe", 32'((n_cmd - c0) * 16 + (n_addr - a0)), 32'h11);
      if (VECS[i].op == 8'h02) begin
        send_byte(VECS[i].wd);
        repeat (2) @(negedge clk);
        chk("R7 program write byte", 32'(wdat), 32'(VECS[i].wd));
        chk("R7 one write strobe", 32'(n_wr - w0), 32'h1);
      end else begin
        oe_acc = 0;
        for (int k = 0; k < int'(VECS[i].dmy); k++) begin
          sclk(4'b0000, d);
          oe_acc |= int'(oe_smp);
        end
        chk("R8 undriven during dummy", 32'(oe_acc), 32'h0);
        recv_byte(b);
        chk("R8 R10 first read byte", 32'(b), 32'(core_fn(base)));
        chk("R6 lane enable in read", 32'(oe_smp),
            32'((VECS[i].mode == 2'b01) ? 4'b0011 : (VECS[i].mode == 2'b10) ? 4'b1111 : 4'b0010));
        recv_byte(b);
        chk("R10 second read byte", 32'(b), 32'(core_fn(base + 8'd1)));
        chk("R10 one byte ahead", 32'(rq_cnt - base), 32'h3);
      end
      desel();
      chk("R2 oe while deselected", 32'(dq_oe), 32'h0);
    end

    // R7: register read without address
    lane_mode = 2'b00; a0 = n_addr; base = rq_cnt;
    sel(); send_byte(8'h9F); recv_byte(b);
    chk("R7 ident read byte", 32'(b), 32'(core_fn(base)));
    chk("R7 ident takes no address", 32'(n_addr - a0), 32'h0);
    desel();

    // R11: abort mid-address, then an other opcode takes write bytes
    a0 = n_addr; w0 = n_wr;
    sel(); send_byte(8'h03); send_byte(8'h11); send_byte(8'h22); desel();
    sel(); send_byte(8'h06);
    repeat (2) @(negedge clk);
    chk("R11 fresh opcode after abort", 32'(cmd_code), 32'h06);
    chk("R11 aborted address not strobed", 32'(n_addr - a0), 32'h0);
    send_byte(8'h5D);
    repeat (2) @(negedge clk);
    chk("R7 write byte after plain opcode", 32'(wdat), 32'h5D);
    chk("R7 write strobe count", 32'(n_wr - w0), 32'h1);
    desel();

    // R4: hold in the middle of an opcode
    sel();
    for (int k = 7; k >= 4; k--) sclk({3'b000, 1'(8'hC3 >> k)}, d);
    hold_n = 1'b0;
    for (int k = 0; k < 4; k++) sclk(4'b0001, d);
    hold_n = 1'b1; repeat (2) @(negedge clk);
    for (int k = 3; k >= 0; k--) sclk({3'b000, 1'(8'hC3 >> k)}, d);
    repeat (2) @(negedge clk);
    chk("R4 opcode survives hold", 32'(cmd_code), 32'hC3);
    desel();

    // R4: hold during read output
    base = rq_cnt;
    sel(); send_byte(8'h05);
    sclk(4'b0000, d); b = {7'b0, d[1]};
    hold_n = 1'b0; repeat (2) @(negedge clk);
    chk("R4 outputs released during hold", 32'(dq_oe), 32'h0);
    sclk(4'b0000, d); sclk(4'b0000, d);
    hold_n = 1'b1; repeat (2) @(negedge clk);
    for (int k = 0; k < 7; k++) begin sclk(4'b0000, d); b = {b[6:0], d[1]}; end
    chk("R4 read resumes after hold", 32'(b), 32'(core_fn(base)));
    desel();

    // R5: quad mode ignores hold
    lane_mode = 2'b10; hold_n = 1'b0;
    sel(); send_byte(8'h02); send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h96);
    repeat (2) @(negedge clk);
    chk("R5 quad address with hold low", 32'(addr_val), 32'h5AC396);
    desel(); hold_n = 1'b1;

    chk("R12 lanes stable while clock high", 32'(glitches), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule